// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a small synchronous up-counter, four bits wide by default, whose state register changes only on the rising clock edge. Besides counting it can be preset from a parallel data word and zeroed through an active-low clear. An elaboration parameter decides how that clear acts. In one variant it acts at once, without waiting for the clock. In the other it takes effect at the next rising edge.

Counting is gated by two enables. The carry output depends only on the second of them, the chain enable, and on the counter holding its all-ones value. To build a wider counter, connect the carry output of each stage to the chain enable of the stage above, and drive every stage's count enable from one shared signal. No other logic is needed. A shorter count cycle of length N comes from decoding the value N-1 onto the clear input of a synchronous-clear instance.

Top module: `casc_counter`

## Requirements
- R1: With ASYNC_CLEAR=1, driving zero_n low sets count to 0 without waiting for a clock edge. While zero_n stays low, count stays 0 whatever preset_n, the enables or the clock do.
- R2: With ASYNC_CLEAR=0, zero_n low at a rising edge makes count 0 after that edge, whatever the enables are. Before that edge count keeps its value.
- R3: With zero_n high and preset_n low, the next rising edge copies preset_val into count, whatever the levels of cnt_en and chain_en.
- R4: With zero_n and preset_n high and both cnt_en and chain_en high, each rising edge adds one to count. It wraps from the all-ones value (15) to 0 and does not saturate.
- R5: With zero_n and preset_n high and either enable low, count holds its value across rising edges.
- R6: carry_out is 1 exactly when chain_en is 1 and count is all ones (15). It follows chain_en in the same cycle, with no clock edge in between.
- R7: Priority at an edge is clear first, then preset, then count, then hold.
- R8: When the carry_out of one instance drives the chain_en of a second instance, and both share cnt_en, the pair counts as one 8-bit counter, {upper, lower}, modulo 256.
- R9: With ASYNC_CLEAR=0 and zero_n driven low whenever count equals 9, the counter steps through 0 to 9 and then returns to 0.
- R10: This sequence holds: clear to 0, preset to 12, count through 13, 14, 15, 0, 1, 2, then hold while counting is inhibited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| zero_n | input | 1 | Active-low clear; asynchronous or synchronous, set by ASYNC_CLEAR |
| preset_n | input | 1 | Active-low parallel preset |
| cnt_en | input | 1 | Count enable; does not affect the carry |
| chain_en | input | 1 | Count enable that also qualifies carry_out |
| preset_val | input | WIDTH | Value loaded by a preset |
| count | output | WIDTH | Counter state |
| carry_out | output | 1 | High when chain_en is high and count is all ones |

## Verification
Count results (preset, increment, hold, synchronous clear) take effect at the first rising edge after the inputs change. The bench drives inputs on a falling edge and reads count on the following falling edge, so exactly one edge lies between stimulus and check. carry_out and the asynchronous clear need no edge. The bench checks them 1 ns after it changes the input, before the next rising edge, and this separates the two clear variants, which share the same stimulus. The cascade and modulo-10 runs compare against a reference counter that the bench advances once per edge.

// File: rtl/cnt_pkg.sv
// Shared types for the cascadable counter.
// Assumes: the op encoding is used only inside the counter.
package cnt_pkg;
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } op_t;
endpackage

// File: rtl/cnt_ctrl.sv
// Decodes the control inputs into one operation, applying the priority
// clear > preset > count > hold.
// Assumes: all inputs are synchronous to the counter clock, apart from an
// asynchronous clear, which the state register handles itself.
module cnt_ctrl
    import cnt_pkg::*;
(
    input  logic zero_n,
    input  logic preset_n,
    input  logic cnt_en,
    input  logic chain_en,
    output op_t  op
);
    // Priority decode of the operation for the next edge.
    always_comb begin
        if (!zero_n)                 op = OP_CLEAR;
        else if (!preset_n)          op = OP_LOAD;
        else if (cnt_en && chain_en) op = OP_COUNT;
        else                         op = OP_HOLD;
    end
endmodule

// File: rtl/cnt_state.sv
// State register of the counter, with next-state selection.
// ASYNC_CLEAR picks an asynchronous or a synchronous clear.
// Assumes: op comes from cnt_ctrl and zero_n is the same clear signal.
module cnt_state
    import cnt_pkg::*;
#(
    parameter int WIDTH       = 4,
    parameter bit ASYNC_CLEAR = 1'b1
) (
    input  logic             clk,
    input  logic             zero_n,
    input  op_t              op,
    input  logic [WIDTH-1:0] preset_val,
    output logic [WIDTH-1:0] count
);
    logic [WIDTH-1:0] nxt;

    // Select the value loaded at the next edge.
    always_comb begin
        case (op)
            OP_CLEAR: nxt = '0;
            OP_LOAD:  nxt = preset_val;
            OP_COUNT: nxt = count + 1'b1;
            default:  nxt = count;
        endcase
    end

    generate
        if (ASYNC_CLEAR) begin : g_async
            // Register that clears at once when zero_n falls.
            always_ff @(posedge clk or negedge zero_n) begin
                if (!zero_n) count <= '0;
                else         count <= nxt;
            end

            AST_ASYNC_ZERO: assert property (@(posedge clk)
                !zero_n |-> count == '0); // R1
        end else begin : g_sync
            // Register whose clear waits for the clock edge.
            always_ff @(posedge clk) begin
                count <= nxt;
            end

            AST_SYNC_ZERO: assert property (@(posedge clk)
                !zero_n |=> count == '0); // R2
        end
    endgenerate
endmodule

// File: rtl/cnt_carry.sv
// Carry-out generation for chaining: all-ones count qualified by chain_en.
// Assumes: purely combinational, so the carry follows chain_en in the same cycle.
module cnt_carry #(
    parameter int WIDTH = 4
) (
    input  logic             chain_en,
    input  logic [WIDTH-1:0] count,
    output logic             carry_out
);
    logic all_ones;

    // Detect the terminal value, then gate it with the chain enable.
    always_comb begin
        all_ones  = &count;
        carry_out = chain_en & all_ones;
    end

    always_comb begin
        AST_CARRY_NEEDS_CHAIN: assert (chain_en || !carry_out); // R6
    end
endmodule

// File: rtl/casc_counter.sv
// Cascadable presettable binary up-counter.
// Assumes: a single clock. zero_n acts asynchronously when ASYNC_CLEAR=1
// and at the clock edge otherwise. Chain stages by tying carry_out to the
// next stage's chain_en and sharing cnt_en between stages.
module casc_counter
    import cnt_pkg::*;
#(
    parameter int WIDTH       = 4,
    parameter bit ASYNC_CLEAR = 1'b1
) (
    input  logic             clk,
    input  logic             zero_n,
    input  logic             preset_n,
    input  logic             cnt_en,
    input  logic             chain_en,
    input  logic [WIDTH-1:0] preset_val,
    output logic [WIDTH-1:0] count,
    output logic             carry_out
);
    op_t op;

    cnt_ctrl u_ctrl (
        .zero_n   (zero_n),
        .preset_n (preset_n),
        .cnt_en   (cnt_en),
        .chain_en (chain_en),
        .op       (op)
    );

    cnt_state #(.WIDTH(WIDTH), .ASYNC_CLEAR(ASYNC_CLEAR)) u_state (
        .clk        (clk),
        .zero_n     (zero_n),
        .op         (op),
        .preset_val (preset_val),
        .count      (count)
    );

    cnt_carry #(.WIDTH(WIDTH)) u_carry (
        .chain_en  (chain_en),
        .count     (count),
        .carry_out (carry_out)
    );

    AST_PRESET_TAKES_DATA: assert property (@(posedge clk) disable iff (!zero_n)
        !preset_n |=> count == $past(preset_val)); // R3
    AST_STEP_UP: assert property (@(posedge clk) disable iff (!zero_n)
        (preset_n && cnt_en && chain_en) |=> count == $past(count) + 1'b1); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!zero_n)
        (preset_n && !(cnt_en && chain_en)) |=> $stable(count)); // R5
    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!zero_n)
        (carry_out && cnt_en && preset_n) |=> count == '0); // R4
endmodule

// File: tb/casc_counter_tb_top.sv
module casc_counter_tb_top;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    int checks = 0;
    int failures = 0;

    // Shared stimulus for the asynchronous (dut_i) and synchronous (dut_s) units
    logic       zn, pn, ce, te;
    logic [3:0] dv;
    logic [3:0] q_i, q_s;
    logic       co_i, co_s;

    casc_counter #(.WIDTH(4), .ASYNC_CLEAR(1'b1)) dut_i (
        .clk(clk), .zero_n(zn), .preset_n(pn), .cnt_en(ce), .chain_en(te),
        .preset_val(dv), .count(q_i), .carry_out(co_i));
    casc_counter #(.WIDTH(4), .ASYNC_CLEAR(1'b0)) dut_s (
        .clk(clk), .zero_n(zn), .preset_n(pn), .cnt_en(ce), .chain_en(te),
        .preset_val(dv), .count(q_s), .carry_out(co_s));

    // Cascaded pairs (one per clear mode) and a modulo-10 unit
    logic       pz_n, pce;
    logic [3:0] la, ha, ls, hs, qm;
    logic       cla, cha, cls, chs, cm, mz_n;

    casc_counter #(.WIDTH(4), .ASYNC_CLEAR(1'b1)) lo_a (
        .clk(clk), .zero_n(pz_n), .preset_n(1'b1), .cnt_en(pce), .chain_en(1'b1),
        .preset_val(4'd0), .count(la), .carry_out(cla));
    casc_counter #(.WIDTH(4), .ASYNC_CLEAR(1'b1)) hi_a (
        .clk(clk), .zero_n(pz_n), .preset_n(1'b1), .cnt_en(pce), .chain_en(cla),
        .preset_val(4'd0), .count(ha), .carry_out(cha));
    casc_counter #(.WIDTH(4), .ASYNC_CLEAR(1'b0)) lo_s (
        .clk(clk), .zero_n(pz_n), .preset_n(1'b1), .cnt_en(pce), .chain_en(1'b1),
        .preset_val(4'd0), .count(ls), .carry_out(cls));
    casc_counter #(.WIDTH(4), .ASYNC_CLEAR(1'b0)) hi_s (
        .clk(clk), .zero_n(pz_n), .preset_n(1'b1), .cnt_en(pce), .chain_en(cls),
        .preset_val(4'd0), .count(hs), .carry_out(chs));

    assign mz_n = pz_n & (qm != 4'd9);
    casc_counter #(.WIDTH(4), .ASYNC_CLEAR(1'b0)) mod_m (
        .clk(clk), .zero_n(mz_n), .preset_n(1'b1), .cnt_en(1'b1), .chain_en(1'b1),
        .preset_val(4'd0), .count(qm), .carry_out(cm));

    // Row: {zero_n, preset_n, cnt_en, chain_en, preset_val[3:0], exp_count[3:0], exp_carry}
    localparam int NV = 16;
    localparam logic [12:0] VEC [NV] = '{
        {1'b0, 1'b1, 1'b1, 1'b1, 4'd5,  4'd0,  1'b0},
        {1'b1, 1'b0, 1'b0, 1'b0, 4'd12, 4'd12, 1'b0},
        {1'b1, 1'b1, 1'b1, 1'b1, 4'd0,  4'd13, 1'b0},
        {1'b1, 1'b1, 1'b1, 1'b1, 4'd0,  4'd14, 1'b0},
        {1'b1, 1'b1, 1'b1, 1'b1, 4'd0,  4'd15, 1'b1},
        {1'b1, 1'b1, 1'b1, 1'b1, 4'd0,  4'd0,  1'b0},
        {1'b1, 1'b1, 1'b1, 1'b1, 4'd0,  4'd1,  1'b0},
        {1'b1, 1'b1, 1'b1, 1'b1, 4'd0,  4'd2,  1'b0},
        {1'b1, 1'b1, 1'b0, 1'b1, 4'd0,  4'd2,  1'b0},
        {1'b1, 1'b1, 1'b1, 1'b0, 4'd0,  4'd2,  1'b0},
        {1'b1, 1'b0, 1'b1, 1'b1, 4'd15, 4'd15, 1'b1},
        {1'b1, 1'b1, 1'b1, 1'b0, 4'd0,  4'd15, 1'b0},
        {1'b1, 1'b1, 1'b0, 1'b1, 4'd0,  4'd15, 1'b1},
        {1'b0, 1'b0, 1'b1, 1'b1, 4'd9,  4'd0,  1'b0},
        {1'b1, 1'b0, 1'b1, 1'b1, 4'd7,  4'd7,  1'b0},
        {1'b1, 1'b1, 1'b1, 1'b1, 4'd0,  4'd8,  1'b0}
    };

    function automatic string row_tag(int k);
        case (k)
            0:              return "R2";
            1, 10:          return "R3";
            5, 15:          return "R4";
            8, 9, 11, 12:   return "R5";
            13, 14:         return "R7";
            default:        return "R10";
        endcase
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    initial begin
        #(50000 * 10);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int ref8;
        int mref;
        zn = 1'b1; pz_n = 1'b1; pn = 1'b1; ce = 1'b0; te = 1'b0; dv = '0; pce = 1'b0;
        #1;
        zn = 1'b0; pz_n = 1'b0;
        repeat (3) @(negedge clk);
        // Reset state in both clear modes
        check("R1", q_i, 0);
        check("R2", q_s, 0);
        check("R8", {ha, la}, 0);
        check("R8", {hs, ls}, 0);

        // Vector walk: drive on one falling edge, check on the next
        for (int k = 0; k < NV; k++) begin
            {zn, pn, ce, te, dv} = VEC[k][12:5];
            @(negedge clk);
            check(row_tag(k), q_i, int'(VEC[k][4:1]));
            check(row_tag(k), q_s, int'(VEC[k][4:1]));
            check("R6", co_i, int'(VEC[k][0]));
            check("R6", co_s, int'(VEC[k][0]));
        end

        // Both hold at 8; then clear with a preset and count requested
        ce = 1'b0;
        @(negedge clk);
        check("R5", q_i, 8);
        zn = 1'b0; pn = 1'b0; dv = 4'd3; ce = 1'b1; te = 1'b1;
        #1;
        check("R1", q_i, 0);
        check("R2", q_s, 8);
        @(negedge clk);
        check("R1", q_i, 0);
        check("R7", q_s, 0);
        zn = 1'b1; pn = 1'b1; ce = 1'b0;

        // Carry follows chain_en without an edge
        pn = 1'b0; dv = 4'd15; te = 1'b0;
        @(negedge clk);
        pn = 1'b1;
        check("R6", co_i, 0);
        te = 1'b1;
        #1;
        check("R6", co_i, 1);
        te = 1'b0;
        #1;
        check("R6", co_i, 0);

        // Cascade in both modes, plus the modulo-10 unit
        @(negedge clk);
        pz_n = 1'b1;
        ref8 = 0;
        mref = 0;
        for (int i = 0; i < 300; i++) begin
            pce = (i % 3) != 0;
            @(negedge clk);
            if (pce) ref8 = (ref8 + 1) % 256;
            mref = (mref == 9) ? 0 : mref + 1;
            check("R8", {ha, la}, ref8);
            check("R8", {hs, ls}, ref8);
            check("R9", qm, mref);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule